// File: doc/BRIEF.md
# Event-Driven Multi-Channel PWM Timer

This block generates up to sixteen pulse-width modulated outputs from one shared up-counter. Sixteen match events compare a selected match register against the counter. Each output owns two event masks. Any firing event listed in the set mask drives the output high, and any firing event listed in the clear mask drives it low. When both kinds fire in the same tick, a two-bit per-output resolution code decides the result.

A limit mask names the events that return the counter to zero, so one event, usually the period event, sets a single period shared by every output. Each match register has a shadow copy. The shadows are copied into the active registers at the period boundary, so duty and period changes land cleanly on a period edge. An 8-bit prescaler slows the counting, and a halt bit freezes the whole timer.

Software configures the block through a small word-addressed register bus with combinational read data. A typical setup uses event 0 as the period event and one further event per duty cycle. Each output is set by the period event and cleared by its duty event, or the other way round for inverted polarity.

Top module: `evt_pwm_timer`

## Requirements
- R1: After reset the timer is halted. The counter, prescaler and every output are 0, and every register reads 0 except the control word, which reads 0x0000_0004 (halt set).
- R2: Register addresses: config 0x000 (bit 0 unify, bit 7 no-reload), control 0x004, limit 0x008 (bits 15:0), resolution codes 0x058 (output k in bits 2k+1:2k), active match n 0x100+4n, shadow n 0x200+4n, event control n 0x304+8n, set mask k 0x500+8k, clear mask k 0x504+8k. Written values read back.
- R3: Control bits 12:5 hold a prescale value p. While running, the counter advances once every p+1 clocks.
- R4: While control bit 2 (halt) is 1, the counter, the prescaler and the outputs hold, and no event fires.
- R5: Event n fires on a counter tick when the combine field in bits 13:12 of its control word equals 1 and the match register selected by bits 3:0 equals the counter. Any other combine value disables the event.
- R6: On a tick, an output goes high if some firing event is in its set mask and none is in its clear mask. It goes low in the opposite case.
- R7: When set and clear events fire together for an output, its resolution code decides the result: 0 keeps the level, 1 sets, 2 clears, 3 toggles.
- R8: When a firing event is in the limit mask, the counter goes to 0 at that tick; otherwise it increments. A match value of N-1 on the limit event gives a period of N ticks.
- R9: At a limit tick, every active match register loads its shadow unless config bit 7 is 1. A bus write to an active match register takes effect at once and wins over a same-cycle reload.
- R10: Outputs update on the same edge that advances the counter. With the output set by a period event (match N-1) and cleared by an event matching d < N-1, the output is high for d+1 ticks of every N.
- R11: Reserved bits read 0. In particular, control bit 4 (bidirectional) can never be set, and event control words keep only bits 13:12 and 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 16 | PWM outputs |

## Verification
A wrong counter, prescaler or active match value has no direct port of its own. It shows up on pwm_out as a shifted or missing edge, usually within one period and always within two. The bench runs a cycle-level model of the set, clear, resolve and limit rules beside the design and compares every output on every clock, so a single misplaced edge is reported in the cycle it appears. Directed runs count high ticks over whole periods to pin down duty, prescale, conflict handling and reload behaviour. Register read-back covers the map and the reserved bits.

// File: rtl/evt_pwm_timer.sv
module evt_pwm_timer #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [15:0] pwm_out
);
  localparam int NEV   = 16;
  localparam int NOUT  = 16;
  localparam int IDX_W = $clog2(NEV);

  logic                 cfg_unify, cfg_norel, halt;
  logic [PRE_W-1:0]     pre_div, pre_cnt;
  logic [CNT_W-1:0]     cnt;
  logic [NEV-1:0]       lim_mask;
  logic [2*NOUT-1:0]    res_code;
  logic [CNT_W-1:0]     mat [NEV];
  logic [CNT_W-1:0]     rel [NEV];
  logic [IDX_W-1:0]     ev_sel  [NEV];
  logic [1:0]           ev_comb [NEV];
  logic [NEV-1:0]       set_m [NOUT];
  logic [NEV-1:0]       clr_m [NOUT];
  logic [NEV-1:0]       fire;
  logic                 tick, lim_hit;

  wire       wr      = bus_en & bus_we;
  wire [3:0] page    = bus_addr[11:8];
  wire [3:0] slot_a  = bus_addr[5:2];
  wire [3:0] slot_b  = bus_addr[6:3];
  wire wr_cfg  = wr && bus_addr == 12'h000;
  wire wr_ctl  = wr && bus_addr == 12'h004;
  wire wr_lim  = wr && bus_addr == 12'h008;
  wire wr_res  = wr && bus_addr == 12'h058;
  wire sel_mat = page == 4'h1 && bus_addr[7:6] == 2'b00 && bus_addr[1:0] == 2'b00;
  wire sel_rel = page == 4'h2 && bus_addr[7:6] == 2'b00 && bus_addr[1:0] == 2'b00;
  wire sel_ev  = page == 4'h3 && !bus_addr[7] && bus_addr[2:0] == 3'b100;
  wire sel_set = page == 4'h5 && !bus_addr[7] && bus_addr[2:0] == 3'b000;
  wire sel_clr = page == 4'h5 && !bus_addr[7] && bus_addr[2:0] == 3'b100;
  wire wr_mat  = wr && sel_mat;

  assign tick    = !halt && (pre_cnt >= pre_div);
  assign lim_hit = |(fire & lim_mask);

  always_comb begin
    for (int n = 0; n < NEV; n++)
      fire[n] = tick && ev_comb[n] == 2'd1 && mat[ev_sel[n]] == cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_unify <= 1'b0;
      cfg_norel <= 1'b0;
      halt      <= 1'b1;
      pre_div   <= '0;
      lim_mask  <= '0;
      res_code  <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_unify <= bus_wdata[0];
        cfg_norel <= bus_wdata[7];
      end
      if (wr_ctl) begin
        halt    <= bus_wdata[2];
        pre_div <= bus_wdata[5 +: PRE_W];
      end
      if (wr_lim) lim_mask <= bus_wdata[NEV-1:0];
      if (wr_res) res_code <= bus_wdata[2*NOUT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (!halt) begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) cnt <= lim_hit ? '0 : cnt + 1'b1;
    end
  end

  for (genvar n = 0; n < NEV; n++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mat[n]     <= '0;
        rel[n]     <= '0;
        ev_sel[n]  <= '0;
        ev_comb[n] <= '0;
      end else begin
        if (wr_mat && slot_a == n)
          mat[n] <= bus_wdata[CNT_W-1:0];
        else if (tick && lim_hit && !cfg_norel)
          mat[n] <= rel[n];
        if (wr && sel_rel && slot_a == n) rel[n] <= bus_wdata[CNT_W-1:0];
        if (wr && sel_ev && slot_b == n) begin
          ev_sel[n]  <= bus_wdata[IDX_W-1:0];
          ev_comb[n] <= bus_wdata[13:12];
        end
      end
    end
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    wire s_hit = |(fire & set_m[k]);
    wire c_hit = |(fire & clr_m[k]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        set_m[k]   <= '0;
        clr_m[k]   <= '0;
        pwm_out[k] <= 1'b0;
      end else begin
        if (wr && sel_set && slot_b == k) set_m[k] <= bus_wdata[NEV-1:0];
        if (wr && sel_clr && slot_b == k) clr_m[k] <= bus_wdata[NEV-1:0];
        if (s_hit && c_hit) begin
          case (res_code[2*k +: 2])
            2'd1:    pwm_out[k] <= 1'b1;
            2'd2:    pwm_out[k] <= 1'b0;
            2'd3:    pwm_out[k] <= !pwm_out[k];
            default: pwm_out[k] <= pwm_out[k];
          endcase
        end else if (s_hit) begin
          pwm_out[k] <= 1'b1;
        end else if (c_hit) begin
          pwm_out[k] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 12'h000)      bus_rdata = {24'd0, cfg_norel, 6'd0, cfg_unify};
    else if (bus_addr == 12'h004) bus_rdata = 32'({pre_div, 2'b00, halt, 2'b00});
    else if (bus_addr == 12'h008) bus_rdata = 32'(lim_mask);
    else if (bus_addr == 12'h058) bus_rdata = 32'(res_code);
    else if (sel_mat)             bus_rdata = 32'(mat[slot_a]);
    else if (sel_rel)             bus_rdata = 32'(rel[slot_a]);
    else if (sel_ev)              bus_rdata = {18'd0, ev_comb[slot_b], 8'd0, ev_sel[slot_b]};
    else if (sel_set)             bus_rdata = 32'(set_m[slot_b]);
    else if (sel_clr)             bus_rdata = 32'(clr_m[slot_b]);
  end

  // R8
  limit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim_hit) |=> cnt == '0);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !lim_hit) |=> cnt == $past(cnt) + 1'b1);

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(cnt) && $stable(pre_cnt) && $stable(pwm_out)));

  // R3
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pre_cnt == '0);

  // R9
  reload_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim_hit && !cfg_norel && !(wr_mat && slot_a == 4'd0)) |=> mat[0] == $past(rel[0]));

  // R6
  set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fire & set_m[0]) != '0 && (fire & clr_m[0]) == '0) |=> pwm_out[0]);
endmodule

// File: tb/test_evt_pwm_timer.sv
module test_evt_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pwm_out;
  int errors = 0, checks = 0;

  evt_pwm_timer i_evt_pwm_timer (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic        m_halt, m_norel;
  logic [7:0]  m_div, m_pre;
  logic [31:0] m_cnt;
  logic [15:0] m_lim, m_out;
  logic [31:0] m_res;
  logic [31:0] m_mat [16];
  logic [31:0] m_rel [16];
  logic [3:0]  m_sel [16];
  logic [1:0]  m_comb [16];
  logic [15:0] m_set [16];
  logic [15:0] m_clr [16];
  logic [15:0] t_f;
  logic        t_tick, t_lim;

  function automatic logic resolve(logic cur, logic s, logic c, logic [1:0] code);
    if (s && c) begin
      case (code)
        2'd1: return 1'b1;
        2'd2: return 1'b0;
        2'd3: return !cur;
        default: return cur;
      endcase
    end
    if (s) return 1'b1;
    if (c) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_halt <= 1'b1; m_norel <= 1'b0; m_div <= '0; m_pre <= '0; m_cnt <= '0;
      m_lim <= '0; m_out <= '0; m_res <= '0;
      for (int n = 0; n < 16; n++) begin
        m_mat[n] <= '0; m_rel[n] <= '0; m_sel[n] <= '0; m_comb[n] <= '0;
        m_set[n] <= '0; m_clr[n] <= '0;
      end
    end else begin
      t_tick = !m_halt && (m_pre >= m_div);
      for (int n = 0; n < 16; n++)
        t_f[n] = t_tick && m_comb[n] == 2'd1 && m_mat[m_sel[n]] == m_cnt;
      t_lim = |(t_f & m_lim);
      if (!m_halt) begin
        m_pre <= t_tick ? 8'd0 : m_pre + 8'd1;
        if (t_tick) m_cnt <= t_lim ? 32'd0 : m_cnt + 32'd1;
      end
      if (t_tick && t_lim && !m_norel)
        for (int n = 0; n < 16; n++) m_mat[n] <= m_rel[n];
      for (int k = 0; k < 16; k++)
        m_out[k] <= resolve(m_out[k], |(t_f & m_set[k]), |(t_f & m_clr[k]), m_res[2*k +: 2]);
      if (bus_en && bus_we) begin
        int a;
        a = int'(bus_addr);
        if (a == 0) begin m_norel <= bus_wdata[7]; end
        if (a == 4) begin m_halt <= bus_wdata[2]; m_div <= bus_wdata[12:5]; end
        if (a == 8) m_lim <= bus_wdata[15:0];
        if (a == 'h58) m_res <= bus_wdata;
        if (a >= 'h100 && a < 'h140 && a % 4 == 0) m_mat[(a - 'h100) / 4] <= bus_wdata;
        if (a >= 'h200 && a < 'h240 && a % 4 == 0) m_rel[(a - 'h200) / 4] <= bus_wdata;
        if (a >= 'h304 && a < 'h380 && (a - 'h304) % 8 == 0) begin
          m_sel[(a - 'h304) / 8]  <= bus_wdata[3:0];
          m_comb[(a - 'h304) / 8] <= bus_wdata[13:12];
        end
        if (a >= 'h500 && a < 'h580 && (a - 'h500) % 8 == 0) m_set[(a - 'h500) / 8] <= bus_wdata[15:0];
        if (a >= 'h504 && a < 'h580 && (a - 'h504) % 8 == 0) m_clr[(a - 'h504) / 8] <= bus_wdata[15:0];
      end
    end
  end

  // every-cycle comparison against the model (R6, R7, R8, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (pwm_out !== m_out) begin
        errors++;
        $display("FAIL R6 pwm_out model mismatch at %0t: actual=%h expected=%h", $time, pwm_out, m_out);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_high(int cycles, output int h);
    h = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (pwm_out[0]) h++;
    end
  endtask

  task automatic setup(int n, int d, int p, int code, int comb);
    do_reset();
    wr(12'h100, 32'(n - 1)); wr(12'h200, 32'(n - 1)); wr(12'h304, 32'h1000);
    wr(12'h008, 32'h1);
    wr(12'h104, 32'(d)); wr(12'h204, 32'(d)); wr(12'h30C, 32'(1 | (comb << 12)));
    wr(12'h500, 32'h1); wr(12'h504, 32'h2);
    wr(12'h058, 32'(code));
    wr(12'h004, 32'(p << 5));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h;
    void'($urandom(32'd2024));
    do_reset();
    // R1 reset state
    chk("R1 outputs", 32'(pwm_out), 32'h0);
    rd(12'h004, d); chk("R1 control", d, 32'h4);
    rd(12'h008, d); chk("R1 limit", d, 32'h0);
    rd(12'h108, d); chk("R1 match2", d, 32'h0);
    // R11 reserved bits
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, d); chk("R11 control", d, 32'h0000_1FE4);
    wr(12'h004, 32'h4);
    wr(12'h314, 32'hFFFF_FFFF); rd(12'h314, d); chk("R11 evctrl", d, 32'h0000_300F);
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, d); chk("R11 config", d, 32'h81);
    wr(12'h000, 32'h1);
    // R2 register map
    wr(12'h058, 32'hA5A5_1234); rd(12'h058, d); chk("R2 resolution", d, 32'hA5A5_1234);
    wr(12'h518, 32'h0001_2345); rd(12'h518, d); chk("R2 set3", d, 32'h2345);
    wr(12'h57C, 32'h0000_BEEF); rd(12'h57C, d); chk("R2 clear15", d, 32'hBEEF);
    wr(12'h23C, 32'h1234_5678); rd(12'h23C, d); chk("R2 shadow15", d, 32'h1234_5678);
    rd(12'h13C, d); chk("R2 match15 untouched", d, 32'h0);

    // R10 duty d=3 of N=8
    setup(8, 3, 0, 1, 1); repeat (40) @(negedge clk);
    count_high(32, h); chk("R10 duty 3 of 8", 32'(h), 32'd16);
    // R7 code 1 (set) at full duty
    setup(8, 7, 0, 1, 1); repeat (40) @(negedge clk);
    count_high(32, h); chk("R7 conflict set", 32'(h), 32'd32);
    // R7 code 2 (clear)
    setup(8, 7, 0, 2, 1); repeat (40) @(negedge clk);
    count_high(32, h); chk("R7 conflict clear", 32'(h), 32'd0);
    // R7 code 3 (toggle)
    setup(8, 7, 0, 3, 1); repeat (40) @(negedge clk);
    count_high(32, h); chk("R7 conflict toggle", 32'(h), 32'd16);
    // R7 code 0 (hold): output never leaves reset level
    setup(8, 7, 0, 0, 1); repeat (40) @(negedge clk);
    count_high(32, h); chk("R7 conflict hold", 32'(h), 32'd0);
    // R3 prescale 1, N=4, d=0 -> 2 of 8 clocks
    setup(4, 0, 1, 1, 1); repeat (40) @(negedge clk);
    count_high(32, h); chk("R3 prescale", 32'(h), 32'd8);
    // R5 combine value 2 disables the clear event
    setup(8, 3, 0, 1, 2); repeat (40) @(negedge clk);
    count_high(32, h); chk("R5 combine disable", 32'(h), 32'd32);
    // R4 halt freezes outputs
    setup(8, 3, 0, 1, 1); repeat (21) @(negedge clk);
    wr(12'h004, 32'h4);
    begin
      logic [15:0] snap;
      snap = pwm_out;
      repeat (20) @(negedge clk);
      chk("R4 halt hold", 32'(pwm_out), 32'(snap));
    end
    wr(12'h004, 32'h0);
    // R9 shadow reload changes duty at boundary
    setup(8, 3, 0, 1, 1); repeat (40) @(negedge clk);
    wr(12'h204, 32'd5); repeat (20) @(negedge clk);
    count_high(32, h); chk("R9 reload applied", 32'(h), 32'd24);
    // R9 no-reload keeps the old duty
    setup(8, 3, 0, 1, 1); wr(12'h000, 32'h81); repeat (40) @(negedge clk);
    wr(12'h204, 32'd5); repeat (20) @(negedge clk);
    count_high(32, h); chk("R9 reload suppressed", 32'(h), 32'd16);
    // R9 direct match write takes effect at once
    wr(12'h104, 32'd1); repeat (20) @(negedge clk);
    count_high(32, h); chk("R9 direct match", 32'(h), 32'd8);

    // random configurations checked every cycle by the model (R5, R6, R8)
    for (int it = 0; it < 12; it++) begin
      int n;
      do_reset();
      n = 2 + int'($urandom % 20);
      wr(12'h000, ($urandom % 3 == 0) ? 32'h81 : 32'h1);
      wr(12'h100, 32'(n - 1)); wr(12'h200, 32'(n - 1)); wr(12'h304, 32'h1000);
      wr(12'h008, 32'h1 | (($urandom % 4 == 0) ? ($urandom & 32'hFFFE) : 32'h0));
      for (int e = 1; e < 16; e++) begin
        logic [31:0] m, sel, cb;
        m = $urandom % 32'(n + 2);
        sel = ($urandom % 4 == 0) ? $urandom % 16 : 32'(e);
        cb = ($urandom % 5 == 0) ? $urandom % 4 : 32'd1;
        wr(12'h100 + 12'(4 * e), m); wr(12'h200 + 12'(4 * e), m);
        wr(12'h304 + 12'(8 * e), sel | (cb << 12));
      end
      for (int k = 0; k < 16; k++) begin
        wr(12'h500 + 12'(8 * k), $urandom & $urandom & 32'hFFFF);
        wr(12'h504 + 12'(8 * k), $urandom & $urandom & 32'hFFFF);
      end
      wr(12'h058, $urandom);
      wr(12'h004, ($urandom % 3) << 5);
      repeat (60) @(negedge clk);
      wr(12'h200, 32'd1 + $urandom % 20);
      for (int e = 1; e < 4; e++) wr(12'h200 + 12'(4 * e), $urandom % 24);
      repeat (80) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule